// File: doc/BRIEF.md
# Reloadable Interrupt Counter with Scanline Prescaler

This block raises an interrupt after a programmed number of counting events. An 8-bit counter counts upward. When it is clocked while holding its maximum value, it reloads from a software-written latch and raises a sticky, active-high interrupt request. The counter is driven by one of two sources. In cycle mode it counts once per CPU-cycle pulse. In scanline mode a signed prescaler takes 3 off per CPU cycle and adds 341 back whenever the result falls to zero or below, so the counter advances about once per 341 video dots at three dots per CPU cycle.

Software reaches the block through four registers, chosen by a 2-bit select. Decoding of the upper address bits is done by the surrounding logic, and `wr_en` marks an access that falls inside this block's window. Only the low four data bits carry meaning. All pins are plain control pins: a write takes effect on the clock edge where `wr_en` is high, and the block never stalls its writer.

Top module: `irq_reload_counter`

## Requirements
- R1: A write with select 0 sets bits 3:0 of the reload latch from `wr_data[3:0]`. A write with select 1 sets bits 7:4 of the latch from `wr_data[3:0]`. The other half of the latch is kept.
- R2: A write with select 2 stores three fields. `wr_data[2]` is the mode (1 = cycle, 0 = scanline), `wr_data[1]` is the enable, and `wr_data[0]` is a saved re-enable bit. If the new enable is 1, the counter is loaded from the latch and the prescaler is set to 341. The interrupt is cleared in every case.
- R3: A write with select 3 copies the saved re-enable bit into the enable and clears the interrupt. The counter and the prescaler are left unchanged.
- R4: While enabled in cycle mode, the counter is clocked once on every edge where `cpu_tick` is high.
- R5: While enabled in scanline mode, each `cpu_tick` takes 3 off the prescaler. When the result is 0 or less, 341 is added to it and the counter is clocked once. Starting from 341, the counter is clocked after 114, 114 and then 113 ticks, and that pattern repeats.
- R6: Clocking the counter at 0xFF reloads it from the latch and asserts `irq`. Clocking it at any other value adds one.
- R7: `irq` stays high until a write with select 2 or 3. Further overflows while it is high keep it high.
- R8: While the enable is 0, `cpu_tick` has no effect on the counter or the prescaler.
- R9: Reset clears the latch, mode, enable, saved re-enable bit, counter, prescaler and `irq`.
- R10: When a register write and a counting tick fall on the same edge, the write wins for each field it modifies. Counting still proceeds for the fields the write leaves untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 latch low, 1 latch high, 2 control, 3 re-enable |
| wr_data | input | 4 | Write data |
| cpu_tick | input | 1 | One-cycle pulse per CPU cycle |
| irq | output | 1 | Sticky interrupt request, active high |

## Verification
Every result is registered once. A write or a tick applied before edge N is visible on `irq` right after edge N. An overflow therefore shows on `irq` after the same edge that clocks the counter from 0xFF. The bench drives inputs on the falling edge and samples `irq` on the following falling edge. For each programmed latch and mode it computes how many ticks are needed, checks that `irq` is still low one tick early, and then checks that it is high exactly on the expected tick. Scanline counts come from the 114/114/113 cadence.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    SEL_LATCH_LO = 2'd0,
    SEL_LATCH_HI = 2'd1,
    SEL_CTRL     = 2'd2,
    SEL_REARM    = 2'd3
  } reg_sel_e;

  localparam int CTRL_MODE_BIT  = 2;
  localparam int CTRL_EN_BIT    = 1;
  localparam int CTRL_REARM_BIT = 0;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW/2-1:0] wr_data,
  output logic [CW-1:0] latch,
  output logic          cycle_mode,
  output logic          enable,
  output logic          start_load,
  output logic          irq_clear
);
  localparam int HW = CW / 2;

  logic rearm_q;
  logic sel_ctrl, sel_rearm, ctrl_unused;

  assign sel_ctrl    = wr_en && (wr_sel == SEL_CTRL);
  assign sel_rearm   = wr_en && (wr_sel == SEL_REARM);
  assign start_load  = sel_ctrl && wr_data[CTRL_EN_BIT];
  assign irq_clear   = sel_ctrl || sel_rearm;
  assign ctrl_unused = ^wr_data[HW-1:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch      <= '0;
      cycle_mode <= 1'b0;
      enable     <= 1'b0;
      rearm_q    <= 1'b0;
    end else if (wr_en) begin
      unique case (reg_sel_e'(wr_sel))
        SEL_LATCH_LO: latch[HW-1:0]  <= wr_data;
        SEL_LATCH_HI: latch[CW-1:HW] <= wr_data;
        SEL_CTRL: begin
          cycle_mode <= wr_data[CTRL_MODE_BIT];
          enable     <= wr_data[CTRL_EN_BIT];
          rearm_q    <= wr_data[CTRL_REARM_BIT];
        end
        SEL_REARM: enable <= rearm_q;
        default: ;
      endcase
    end
  end

  assert_rearm_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rearm |=> (enable == $past(rearm_q)));
  assert_ctrl_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ctrl |=> (enable == $past(wr_data[CTRL_EN_BIT]) &&
                  cycle_mode == $past(wr_data[CTRL_MODE_BIT])));
  assert_latch_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(latch));
endmodule

// File: rtl/irqc_prescale.sv
module irqc_prescale #(
  parameter int PERIOD = 341,
  parameter int STEP   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic load,
  output logic step_out
);
  localparam int PW = $clog2(PERIOD + 1) + 1;
  localparam logic signed [PW-1:0] P_S    = PW'(PERIOD);
  localparam logic signed [PW-1:0] STEP_S = PW'(STEP);
  localparam logic signed [PW-1:0] ZERO_S = '0;

  logic signed [PW-1:0] ps_q, ps_dec;
  logic wrap;

  assign ps_dec   = ps_q - STEP_S;
  assign wrap     = (ps_dec <= ZERO_S);
  assign step_out = run && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ps_q <= '0;
    else if (load)   ps_q <= P_S;
    else if (run)    ps_q <= wrap ? (ps_dec + P_S) : ps_dec;
  end

  assert_ps_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_q >= ZERO_S) && (ps_q <= P_S));
  assert_ps_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(ps_q));
  assert_ps_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ps_q == P_S));
endmodule

// File: rtl/irqc_counter.sv
module irqc_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          load,
  input  logic          clear,
  input  logic [CW-1:0] reload_val,
  output logic          irq
);
  localparam logic [CW-1:0] MAXV = '1;

  logic [CW-1:0] cnt_q;
  logic          ovf;

  assign ovf = step && (cnt_q == MAXV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= reload_val;
    else if (step) cnt_q <= ovf ? reload_val : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq <= 1'b0;
    else if (clear) irq <= 1'b0;
    else if (ovf)   irq <= 1'b1;
  end

  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clear) |=> irq);
  assert_irq_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !irq);
  assert_overflow_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !clear && cnt_q == MAXV) |=> (irq && cnt_q == $past(reload_val)));
  assert_count_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/irq_reload_counter.sv
module irq_reload_counter #(
  parameter int CW     = 8,
  parameter int PERIOD = 341,
  parameter int STEP   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW/2-1:0] wr_data,
  input  logic          cpu_tick,
  output logic          irq
);
  logic [CW-1:0] latch;
  logic cycle_mode, enable, start_load, irq_clear;
  logic live_tick, ps_step, cnt_step;

  assign live_tick = enable && cpu_tick;

  irqc_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .latch(latch), .cycle_mode(cycle_mode), .enable(enable),
    .start_load(start_load), .irq_clear(irq_clear)
  );

  irqc_prescale #(.PERIOD(PERIOD), .STEP(STEP)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(live_tick && !cycle_mode),
    .load(start_load), .step_out(ps_step)
  );

  assign cnt_step = (live_tick && cycle_mode) || ps_step;

  irqc_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(cnt_step), .load(start_load),
    .clear(irq_clear), .reload_val(latch), .irq(irq)
  );

  assert_no_step_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !cnt_step);
endmodule

// File: tb/irq_reload_counter_bench.sv
module irq_reload_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int NV = 8;
  // mode (1 cycle / 0 scanline), latch, ticks until irq
  localparam int VEC [NV][3] = '{
    '{1, 'hFC, 4}, '{1, 'hFF, 1}, '{1, 'h00, 256}, '{1, 'h80, 128},
    '{0, 'hFF, 114}, '{0, 'hFE, 228}, '{0, 'hFD, 341}, '{0, 'hFC, 455}
  };

  logic clk = 0, rst_n = 0, wr_en = 0, cpu_tick = 0;
  logic [1:0] wr_sel = 0;
  logic [3:0] wr_data = 0;
  logic irq;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_reload_counter u_irq_reload_counter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cpu_tick(cpu_tick), .irq(irq)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s irq actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [3:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic ticks(int n);
    cpu_tick = 1;
    repeat (n) @(negedge clk);
    cpu_tick = 0;
  endtask

  task automatic set_latch(logic [7:0] v);
    wr(2'd0, v[3:0]);
    wr(2'd1, v[7:4]);
  endtask

  task automatic run_all();
    chk("R9 reset", irq, 1'b0);
    @(negedge clk); rst_n = 1; @(negedge clk);
    ticks(300);
    chk("R9 R8 disabled after reset", irq, 1'b0);
    wr(2'd3, 4'h0);
    ticks(300);
    chk("R9 rearm bit reset to zero", irq, 1'b0);

    for (int i = 0; i < NV; i++) begin
      set_latch(8'(VEC[i][1]));                         // R1
      wr(2'd2, {1'b0, 1'(VEC[i][0]), 2'b11});            // R2
      ticks(VEC[i][2] - 1);
      chk(VEC[i][0] ? "R4 R6 early" : "R5 R6 early", irq, 1'b0);
      ticks(1);
      chk(VEC[i][0] ? "R4 R6 overflow" : "R5 R6 overflow", irq, 1'b1);
      wr(2'd2, 4'h0);
      chk("R2 clear", irq, 1'b0);
    end

    // R7 sticky across further overflows, R3 clears
    set_latch(8'hFF); wr(2'd2, 4'b0111);
    ticks(1); chk("R7 set", irq, 1'b1);
    ticks(5); chk("R7 sticky", irq, 1'b1);
    wr(2'd3, 4'h0); chk("R3 clear", irq, 1'b0);
    ticks(1); chk("R6 reload from latch", irq, 1'b1);

    // R6 reload value FE needs two more ticks
    set_latch(8'hFE); wr(2'd2, 4'b0111);
    ticks(2); chk("R6 first", irq, 1'b1);
    wr(2'd3, 4'h0);
    ticks(1); chk("R6 reload not yet", irq, 1'b0);
    ticks(1); chk("R6 reload overflow", irq, 1'b1);

    // R3 rearm keeps counter; R8 ticks ignored while disabled
    set_latch(8'hF0); wr(2'd2, 4'b0111);
    ticks(2);
    wr(2'd2, 4'b0101);
    ticks(10); chk("R8 disabled", irq, 1'b0);
    wr(2'd3, 4'h0);
    ticks(13); chk("R3 counter kept early", irq, 1'b0);
    ticks(1); chk("R3 counter kept overflow", irq, 1'b1);

    // R3 with rearm bit 0 disables
    set_latch(8'hFF); wr(2'd2, 4'b0110);
    wr(2'd3, 4'h0);
    ticks(5); chk("R3 rearm zero disables", irq, 1'b0);

    // R5 prescaler kept through disable and rearm
    wr(2'd2, 4'b0011);
    ticks(50);
    wr(2'd2, 4'b0001);
    ticks(20);
    wr(2'd3, 4'h0);
    ticks(63); chk("R5 prescaler kept early", irq, 1'b0);
    ticks(1); chk("R5 prescaler kept count", irq, 1'b1);

    // R10 write and tick on the same edge
    set_latch(8'hFE); wr(2'd2, 4'b0111);
    cpu_tick = 1; wr(2'd3, 4'h0); cpu_tick = 0;
    chk("R10 clear wins", irq, 1'b0);
    ticks(1); chk("R10 tick still counted", irq, 1'b1);
  endtask

  initial begin
    fork
      begin run_all(); end
      begin
        repeat (WATCHDOG) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule